// File: doc/BRIEF.md
# March Test Sequencer for Word-Wide RAM

This block is a built-in self-test controller for a word-wide single-port RAM that sits outside it. After one `start` pulse it takes over the RAM's address, write-data, write-enable and read-enable lines. It then runs a march test whose run time grows linearly with the number of words. The test has three elements, run once with an all-zeros background and once with an all-ones background:

- A fill element writes the background to every word.
- An ascending element goes from the lowest address up. At each word it reads the word, expects the background, and writes the complement.
- A descending element goes from the highest address down. At each word it reads the word, expects the complement, and writes the background back.

A final verify element reads every word in ascending order and expects the all-ones background left by the second pass.

Read data is compared one cycle after each read is issued. The first mismatch sets a sticky fail flag and latches the failing address and the value that was expected there. The test always runs to completion, whether or not a mismatch occurs.

The controller's states are:

| State | What it does | Next state |
|---|---|---|
| IDLE | Waits for `start`. | `start` goes to FILL (first pass, address 0). |
| FILL | Writes the background, address ascending. | UP_RD after the top address. |
| UP_RD | Issues the read at the current address. | UP_WR. |
| UP_WR | Writes the complement. | UP_RD, or DN_RD loaded at the top address after the top. |
| DN_RD | Issues the read at the current address. | DN_WR. |
| DN_WR | Writes the background. | DN_RD, or after address 0: FILL for the second pass, or VERIFY after the second pass. |
| VERIFY | Reads every address, ascending. | DRAIN after the top address. |
| DRAIN | Waits one cycle so the last comparison can complete. | DONE. |
| DONE | Holds the results. | `start` begins a new run. |

Top module: `march_bist`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `mem_we` and `mem_re` are all low.
- R2: The first N busy cycles of a run are writes of the pass background to addresses 0, 1, … N-1 in order. N is 2^ADDR_W. The background is all zeros on the first pass and all ones on the second.
- R3: The ascending element then takes two cycles per address, from address 0 upward. The first cycle issues a read and the second writes the complement of the background to the same address. The write is never issued before its read.
- R4: The descending element takes two cycles per address, from address N-1 down to address 0. The first cycle issues a read (the expected value is the complement of the background). The second cycle writes the background to the same address.
- R5: After the first pass, which uses the all-zeros background, the three elements repeat once with every data value complemented.
- R6: A verify element then reads addresses 0 to N-1 in order, one per cycle, and expects all ones. A fault-free RAM therefore ends the run holding all ones.
- R7: `busy` stays high for exactly 11·N+1 cycles after `start` is accepted. Then `done` rises and `busy` falls, and `done` holds until the next accepted start.
- R8: `mem_rdata` is compared with the expected word in the cycle after the read. The first mismatch sets `fail`, and `fail` stays set to the end of the run. It also latches `fail_addr` and `fail_exp`; later mismatches do not change them.
- R9: `start` is ignored while `busy` is high. A start accepted in IDLE or DONE clears `fail` and begins a new run.
- R10: `mem_we` and `mem_re` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when in IDLE or DONE |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable; data is expected the following cycle |
| mem_rdata | input | DATA_W | RAM read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; results are valid |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_exp | output | DATA_W | Value expected at the first mismatch |

## Verification
The bench builds the sequencer with ADDR_W=3 and DATA_W=4, so one run lasts 89 cycles. This makes it cheap to predict every cycle of every run from the cycle index and compare the whole access trace.

That small size allows a full sweep over fault sites:
- A stuck-at-0 and a stuck-at-1 on every bit of every word.
- An alias fault, where a write to one word also lands on its neighbour, at every address.

For each fault, the bench works out in closed form which element catches it first, at which address and against which expected value. Further runs cover a start pulse issued in the middle of a run and a clean run after a failing one.

// File: rtl/march_pkg.sv
package march_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FILL,
        ST_UP_RD,
        ST_UP_WR,
        ST_DN_RD,
        ST_DN_WR,
        ST_VERIFY,
        ST_DRAIN,
        ST_DONE
    } march_state_t;

    typedef enum logic [2:0] {
        AOP_HOLD,
        AOP_LO,
        AOP_HI,
        AOP_INC,
        AOP_DEC
    } addr_op_t;

endpackage

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
    parameter int ADDR_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  march_pkg::addr_op_t  op,
    output logic [ADDR_W-1:0]    addr,
    output logic                 at_hi,
    output logic                 at_lo
);
    import march_pkg::*;

    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] ONE      = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else begin
            unique case (op)
                AOP_HOLD: addr <= addr;
                AOP_LO:   addr <= '0;
                AOP_HI:   addr <= TOP_ADDR;
                AOP_INC:  addr <= addr + ONE;
                AOP_DEC:  addr <= addr - ONE;
                default:  addr <= addr;
            endcase
        end
    end

    assign at_hi = (addr == TOP_ADDR);
    assign at_lo = (addr == '0);

endmodule

// File: rtl/march_fail_log.sv
module march_fail_log #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rd_issue,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_exp,
    input  logic [DATA_W-1:0] rdata,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_exp
);
    logic              chk_vld;
    logic [ADDR_W-1:0] chk_addr;
    logic [DATA_W-1:0] chk_exp;
    logic              mismatch;

    assign mismatch = chk_vld && (rdata != chk_exp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_vld   <= 1'b0;
            chk_addr  <= '0;
            chk_exp   <= '0;
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
        end else begin
            chk_vld  <= rd_issue && !clr;
            chk_addr <= rd_addr;
            chk_exp  <= rd_exp;
            if (clr) begin
                fail      <= 1'b0;
                fail_addr <= '0;
                fail_exp  <= '0;
            end else if (mismatch && !fail) begin
                fail      <= 1'b1;
                fail_addr <= chk_addr;
                fail_exp  <= chk_exp;
            end
        end
    end

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clr) |=> fail); // R8
    AST_FIRST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clr) |=> ($stable(fail_addr) && $stable(fail_exp))); // R8
    AST_MISMATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch && !clr) |=> fail); // R8

endmodule

// File: rtl/march_bist.sv
module march_bist #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_exp
);
    import march_pkg::*;

    march_state_t      state_q, state_d;
    logic              pol_q, pol_d;
    addr_op_t          aop;
    logic              clr;
    logic              at_hi, at_lo;
    logic [DATA_W-1:0] bg;
    logic [DATA_W-1:0] rd_exp;

    assign bg = {DATA_W{pol_q}};

    march_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (aop),
        .addr  (mem_addr),
        .at_hi (at_hi),
        .at_lo (at_lo)
    );

    march_fail_log #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .rd_issue  (mem_re),
        .rd_addr   (mem_addr),
        .rd_exp    (rd_exp),
        .rdata     (mem_rdata),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_exp  (fail_exp)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pol_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pol_q   <= pol_d;
        end
    end

    // Next state and address control
    always_comb begin
        state_d = state_q;
        pol_d   = pol_q;
        aop     = AOP_HOLD;
        clr     = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_d = ST_FILL;
                    pol_d   = 1'b0;
                    aop     = AOP_LO;
                    clr     = 1'b1;
                end
            end
            ST_FILL: begin
                if (at_hi) begin
                    state_d = ST_UP_RD;
                    aop     = AOP_LO;
                end else begin
                    aop = AOP_INC;
                end
            end
            ST_UP_RD: state_d = ST_UP_WR;
            ST_UP_WR: begin
                if (at_hi) begin
                    state_d = ST_DN_RD;
                    aop     = AOP_HI;
                end else begin
                    state_d = ST_UP_RD;
                    aop     = AOP_INC;
                end
            end
            ST_DN_RD: state_d = ST_DN_WR;
            ST_DN_WR: begin
                if (!at_lo) begin
                    state_d = ST_DN_RD;
                    aop     = AOP_DEC;
                end else if (!pol_q) begin
                    state_d = ST_FILL;
                    pol_d   = 1'b1;
                    aop     = AOP_LO;
                end else begin
                    state_d = ST_VERIFY;
                    aop     = AOP_LO;
                end
            end
            ST_VERIFY: begin
                if (at_hi) state_d = ST_DRAIN;
                else       aop     = AOP_INC;
            end
            ST_DRAIN: state_d = ST_DONE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = '0;
        rd_exp    = '0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            ST_FILL: begin
                mem_we    = 1'b1;
                mem_wdata = bg;
            end
            ST_UP_RD: begin
                mem_re = 1'b1;
                rd_exp = bg;
            end
            ST_UP_WR: begin
                mem_we    = 1'b1;
                mem_wdata = ~bg;
            end
            ST_DN_RD: begin
                mem_re = 1'b1;
                rd_exp = ~bg;
            end
            ST_DN_WR: begin
                mem_we    = 1'b1;
                mem_wdata = bg;
            end
            ST_VERIFY: begin
                mem_re = 1'b1;
                rd_exp = bg;
            end
            ST_DRAIN: ;
            default:  busy = 1'b0;
        endcase
    end

    AST_UP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP_RD) |=> (state_q == ST_UP_WR && $stable(mem_addr))); // R3
    AST_DN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DN_RD) |=> (state_q == ST_DN_WR && $stable(mem_addr))); // R4
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (aop == AOP_INC) |-> !at_hi); // R2
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && state_q != ST_DRAIN) |=> busy); // R9
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R7
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (!mem_we && !mem_re)); // R10

endmodule

// File: tb/sim_march_bist.sv
module sim_march_bist;
    localparam int AW = 3;
    localparam int DW = 4;
    localparam int N  = 1 << AW;
    localparam int RUN_LEN = 11 * N + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we, mem_re;
    logic [DW-1:0] mem_rdata;
    logic          busy, done, fail;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_exp;

    int checks = 0;
    int fails  = 0;

    // Fault model: 0 none, 1 stuck bit on read, 2 write alias to addr^1
    int fmode = 0;
    int faddr = 0;
    int fbit  = 0;
    int fval  = 0;
    logic [DW-1:0] mem [N];

    always #2 clk = ~clk;

    march_bist #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
        .fail_addr(fail_addr), .fail_exp(fail_exp)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            if (fmode == 2 && int'(mem_addr) == faddr)
                mem[mem_addr ^ 1] <= mem_wdata;
        end
        if (mem_re) begin
            logic [DW-1:0] v;
            v = mem[mem_addr];
            if (fmode == 1 && int'(mem_addr) == faddr) v[fbit] = fval[0];
            mem_rdata <= v;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void expop(input int k, output logic we, output logic re,
                                  output int a, output int d);
        we = 1'b0; re = 1'b0; a = 0; d = 0;
        if (k < 10 * N) begin
            int p;
            int l;
            int bgv;
            p = k / (5 * N);
            l = k % (5 * N);
            bgv = (p != 0) ? (1 << DW) - 1 : 0;
            if (l < N) begin
                we = 1'b1; a = l; d = bgv;
            end else if (l < 3 * N) begin
                int j;
                j = l - N;
                a = j / 2;
                if (j % 2 == 0) re = 1'b1;
                else begin we = 1'b1; d = bgv ^ ((1 << DW) - 1); end
            end else begin
                int j;
                j = l - 3 * N;
                a = N - 1 - j / 2;
                if (j % 2 == 0) re = 1'b1;
                else begin we = 1'b1; d = bgv; end
            end
        end else if (k < 11 * N) begin
            re = 1'b1; a = k - 10 * N;
        end
    endfunction

    // One complete run; checks trace (R2..R6, R10), length (R7), result (R8, R9)
    task automatic run(input bit exp_fail, input int exp_fa, input int exp_fe,
                       input bit mid_start, input string tag);
        int k;
        int bad;
        int bad_k;
        for (int i = 0; i < N; i++) mem[i] = 4'h5;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(fail == 1'b0, "R9", {tag, " fail cleared on start"}, fail, 0);
        k = 0; bad = 0; bad_k = -1;
        while (busy && k < 1000) begin
            logic we_e, re_e;
            int a_e, d_e;
            expop(k, we_e, re_e, a_e, d_e);
            if (mem_we !== we_e || mem_re !== re_e ||
                ((we_e || re_e) && int'(mem_addr) != a_e) ||
                (we_e && int'(mem_wdata) != d_e)) begin
                if (bad == 0) bad_k = k;
                bad++;
            end
            if (mid_start) start = (k == 20 || k == 60);
            k++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(bad == 0, "R2 R3 R4 R5 R6 R10", {tag, " access trace, first bad cycle"}, bad_k, -1);
        chk(k == RUN_LEN, "R7", {tag, " busy cycles"}, k, RUN_LEN);
        chk(done && !busy, "R7", {tag, " done after run"}, done, 1);
        chk(fail == exp_fail, "R8", {tag, " fail flag"}, fail, exp_fail);
        if (exp_fail) begin
            chk(int'(fail_addr) == exp_fa, "R8", {tag, " first fail addr"}, fail_addr, exp_fa);
            chk(int'(fail_exp) == exp_fe, "R8", {tag, " first fail expected"}, fail_exp, exp_fe);
        end
        repeat (3) @(negedge clk);
        chk(done && !mem_we && !mem_re, "R7", {tag, " done holds idle"}, done, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fail && !mem_we && !mem_re, "R1", "reset outputs",
            {busy, done, fail, mem_we, mem_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R1", "idle after reset", busy, 0);

        // Clean run: final contents all ones
        fmode = 0;
        run(1'b0, 0, 0, 1'b0, "clean");
        begin
            int nz;
            nz = 0;
            for (int i = 0; i < N; i++) if (mem[i] != 4'hF) nz++;
            chk(nz == 0, "R6", "words not all ones after clean run", nz, 0);
        end

        // Stuck bit sweep
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < DW; b++) begin
                for (int v = 0; v < 2; v++) begin
                    fmode = 1; faddr = a; fbit = b; fval = v;
                    // Stuck-1 is caught by the ascending read (expect 0);
                    // stuck-0 by the descending read (expect all ones).
                    run(1'b1, a, (v != 0) ? 0 : 15, 1'b0, "stuck");
                end
            end
        end

        // Alias sweep
        for (int a = 0; a < N; a++) begin
            fmode = 2; faddr = a;
            if (a % 2 == 0) run(1'b1, a + 1, 0, 1'b0, "alias");
            else            run(1'b1, a - 1, 15, 1'b0, "alias");
        end

        // Start pulses during a run are ignored; fault-free run after faults clears fail
        fmode = 0;
        run(1'b0, 0, 0, 1'b1, "midstart");

        // Fault run with mid-run start: result and first failure unchanged
        fmode = 1; faddr = 5; fbit = 2; fval = 1;
        run(1'b1, 5, 0, 1'b1, "midstart_fault");
        fmode = 0;
        run(1'b0, 0, 0, 1'b0, "restart");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule